// File: doc/BRIEF.md
# Token-Passing Transmit Handshake Sequencer

This block runs one transmit attempt each time the node is handed the token on a token-passing bus. The processor writes a destination ID and a transmit-enable command. On the next token arrival the sequencer asks the frame sender for a free-buffer enquiry to that ID. A positive reply leads to a data-packet request; the frame sender appends the 16-bit CRC and reports completion. The sequencer then waits for the receiver's post-packet acknowledgement. A negative reply, or no reply at all, skips the packet. Every attempt ends with a token-pass request, and the sequencer goes back to idle.

A two-bit status word and a two-bit interrupt mask sit beside the sequencer. Status bit 0 reports that the transmitter is available. Status bit 1 reports delivery confirmed by an acknowledgement. The interrupt output is high while any unmasked status bit is set. The line coding, buffer RAM, CRC datapath and the receive decoder are outside the block. They are represented by single-cycle request pulses and single-cycle ACK, NAK and packet-done inputs.

The sequencer has these states:
- `S_IDLE` moves to `S_ENQ` on a token when a transmission is pending, and to `S_PASS` on a token when none is pending.
- `S_ENQ` moves to `S_WRSP`.
- `S_WRSP` moves to `S_DATA` on ACK. It moves to `S_PASS` on NAK, or when the response window expires.
- `S_DATA` moves to `S_WSENT`.
- `S_WSENT` moves to `S_WACK` on packet-done.
- `S_WACK` moves to `S_PASS` on ACK, or when the response window expires.
- `S_PASS` moves to `S_IDLE`.

Top module: `tkn_tx_seq`

## Requirements
- R1: A transmission starts only when `token_in` is high in an idle cycle while a transmit-enable is pending. `req_enq` is then high for exactly the next cycle, and `req_dest` equals the ID latched with the enable.
- R2: An `rx_ack` while waiting for the enquiry reply raises `req_pkt` for exactly the next cycle. If `rx_ack` and `rx_nak` arrive together, `rx_ack` wins. After `pkt_done` the sequencer waits for the post-packet reply.
- R3: An `rx_nak` (without `rx_ack`) while waiting for the enquiry reply skips the packet. `req_pass` is high in the next cycle and `req_pkt` never rises in that attempt.
- R4: Each wait for a reply lasts at most RESP_CYC cycles. A reply in the RESP_CYC-th wait cycle is still accepted. With no reply, `req_pass` rises exactly RESP_CYC cycles after the wait began.
- R5: Status bit 1 (delivery confirmed) is set at the end of the attempt only when `rx_ack` followed the packet. When there is silence after the packet, the attempt ends with status bit 1 clear.
- R6: Status bit 0 (transmitter available) clears on the clock edge that accepts a transmit-enable. It sets again on the edge that enters the token-pass cycle at the end of an attempt, whatever the outcome.
- R7: Every attempt ends with a single-cycle `req_pass` followed by idle. At most one of `req_enq`, `req_pkt` and `req_pass` is high in any cycle.
- R8: A token arriving with no pending transmission produces only a single-cycle `req_pass` in the next cycle. The status is unchanged.
- R9: `cmd_disable` cancels a pending transmission and sets status bit 0, but only in an idle cycle without a token. In any other cycle, `cmd_enable` and `cmd_disable` are ignored: the pending flag, the destination and the status are unchanged. Enable wins over disable if both are high.
- R10: `irq` is high exactly when `status & imask` is non-zero, with mask bit n gating status bit n. `imask` is loaded from `imask_wdata` on a cycle with `imask_we` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_enable | input | 1 | Transmit-enable command pulse |
| cmd_disable | input | 1 | Cancel-pending-transmit command pulse |
| cmd_dest | input | ID_W | Destination ID captured with the enable |
| imask_we | input | 1 | Interrupt mask write strobe |
| imask_wdata | input | ST_W | Interrupt mask write value |
| token_in | input | 1 | Token received, one-cycle pulse |
| rx_ack | input | 1 | Decoded ACK reply, one-cycle pulse |
| rx_nak | input | 1 | Decoded NAK reply, one-cycle pulse |
| pkt_done | input | 1 | Data packet and CRC fully sent |
| req_enq | output | 1 | Request: send free-buffer enquiry |
| req_pkt | output | 1 | Request: send data packet with CRC |
| req_pass | output | 1 | Request: send token-pass frame |
| req_dest | output | ID_W | Destination ID for the requested frames |
| status | output | ST_W | Bit 0 transmitter available, bit 1 delivery confirmed |
| irq | output | 1 | Masked status interrupt |

## Verification
The bench tests when a reply is accepted at the edge of the response window: a reply in the last wait cycle must go through, while silence must end the wait after exactly RESP_CYC cycles. A timer that is off by one would either drop a late reply or cut the wait one cycle short. The bench also sends commands in the middle of an attempt. A sequencer that lets them through would send to a changed destination or start a second attempt on the next token. Further directed tests check that a NAK never produces a packet request, that a token with nothing pending only passes the token, and that interrupts follow the mask bit by bit.

// File: rtl/tkn_tx_pkg.sv
package tkn_tx_pkg;
    localparam int ST_W     = 2;
    localparam int ST_AVAIL = 0;
    localparam int ST_OK    = 1;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ENQ,
        S_WRSP,
        S_DATA,
        S_WSENT,
        S_WACK,
        S_PASS
    } tx_state_t;
endpackage

// File: rtl/tkn_tx_timer.sv
module tkn_tx_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);
endmodule

// File: rtl/tkn_tx_fsm.sv
module tkn_tx_fsm
    import tkn_tx_pkg::*;
#(
    parameter int ID_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            token_in,
    input  logic            cmd_enable,
    input  logic            cmd_disable,
    input  logic [ID_W-1:0] cmd_dest,
    input  logic            rx_ack,
    input  logic            rx_nak,
    input  logic            pkt_done,
    input  logic            tmo_expired,
    output tx_state_t       st,
    output logic            pending,
    output logic [ID_W-1:0] dest_q,
    output logic            tmr_run,
    output logic            req_enq,
    output logic            req_pkt,
    output logic            req_pass,
    output logic            ev_enable,
    output logic            ev_disable,
    output logic            ev_end,
    output logic            ev_ok
);
    tx_state_t nxt;
    logic      idle_free;

    // next-state decision
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE:  if (token_in) nxt = pending ? S_ENQ : S_PASS;
            S_ENQ:   nxt = S_WRSP;
            S_WRSP: begin
                if (rx_ack)                       nxt = S_DATA;
                else if (rx_nak || tmo_expired)   nxt = S_PASS;
            end
            S_DATA:  nxt = S_WSENT;
            S_WSENT: if (pkt_done) nxt = S_WACK;
            S_WACK:  if (rx_ack || tmo_expired) nxt = S_PASS;
            S_PASS:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // outputs and events
    always_comb begin
        idle_free  = (st == S_IDLE) && !token_in;
        ev_enable  = idle_free && cmd_enable;
        ev_disable = idle_free && cmd_disable && !cmd_enable;
        ev_end     = ((st == S_WRSP) || (st == S_WACK)) && (nxt == S_PASS);
        ev_ok      = (st == S_WACK) && rx_ack;
        tmr_run    = (st == S_WRSP) || (st == S_WACK);
        req_enq    = (st == S_ENQ);
        req_pkt    = (st == S_DATA);
        req_pass   = (st == S_PASS);
    end

    // pending command and destination
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            dest_q  <= '0;
        end else if (ev_enable) begin
            pending <= 1'b1;
            dest_q  <= cmd_dest;
        end else if (ev_disable) begin
            pending <= 1'b0;
        end else if ((st == S_IDLE) && token_in) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/tkn_tx_status.sv
module tkn_tx_status
    import tkn_tx_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_enable,
    input  logic            ev_disable,
    input  logic            ev_end,
    input  logic            ev_ok,
    input  logic            imask_we,
    input  logic [ST_W-1:0] imask_wdata,
    output logic [ST_W-1:0] status,
    output logic [ST_W-1:0] imask,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= ST_W'(1) << ST_AVAIL;
        end else if (ev_enable) begin
            status[ST_AVAIL] <= 1'b0;
            status[ST_OK]    <= 1'b0;
        end else if (ev_end) begin
            status[ST_AVAIL] <= 1'b1;
            status[ST_OK]    <= ev_ok;
        end else if (ev_disable) begin
            status[ST_AVAIL] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        imask <= '0;
        else if (imask_we) imask <= imask_wdata;
    end

    assign irq = |(status & imask);
endmodule

// File: rtl/tkn_tx_seq.sv
module tkn_tx_seq
    import tkn_tx_pkg::*;
#(
    parameter int ID_W     = 8,
    parameter int RESP_CYC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_enable,
    input  logic            cmd_disable,
    input  logic [ID_W-1:0] cmd_dest,
    input  logic            imask_we,
    input  logic [ST_W-1:0] imask_wdata,
    input  logic            token_in,
    input  logic            rx_ack,
    input  logic            rx_nak,
    input  logic            pkt_done,
    output logic            req_enq,
    output logic            req_pkt,
    output logic            req_pass,
    output logic [ID_W-1:0] req_dest,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    tx_state_t       st;
    logic            pending;
    logic            tmr_run;
    logic            tmo_expired;
    logic            ev_enable;
    logic            ev_disable;
    logic            ev_end;
    logic            ev_ok;
    logic [ST_W-1:0] imask_q;

    tkn_tx_fsm #(.ID_W(ID_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .token_in   (token_in),
        .cmd_enable (cmd_enable),
        .cmd_disable(cmd_disable),
        .cmd_dest   (cmd_dest),
        .rx_ack     (rx_ack),
        .rx_nak     (rx_nak),
        .pkt_done   (pkt_done),
        .tmo_expired(tmo_expired),
        .st         (st),
        .pending    (pending),
        .dest_q     (req_dest),
        .tmr_run    (tmr_run),
        .req_enq    (req_enq),
        .req_pkt    (req_pkt),
        .req_pass   (req_pass),
        .ev_enable  (ev_enable),
        .ev_disable (ev_disable),
        .ev_end     (ev_end),
        .ev_ok      (ev_ok)
    );

    tkn_tx_timer #(.LIMIT(RESP_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmr_run),
        .expired(tmo_expired)
    );

    tkn_tx_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_enable  (ev_enable),
        .ev_disable (ev_disable),
        .ev_end     (ev_end),
        .ev_ok      (ev_ok),
        .imask_we   (imask_we),
        .imask_wdata(imask_wdata),
        .status     (status),
        .imask      (imask_q),
        .irq        (irq)
    );
endmodule

// File: rtl/tkn_tx_seq_chk.sv
module tkn_tx_seq_chk
    import tkn_tx_pkg::*;
#(
    parameter int RESP_CYC = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            token_in,
    input logic            rx_ack,
    input logic            rx_nak,
    input logic            req_enq,
    input logic            req_pkt,
    input logic            req_pass,
    input logic [ST_W-1:0] status,
    input logic [ST_W-1:0] imask,
    input logic            irq,
    input tx_state_t       st,
    input logic            pending
);
    localparam int WCW = $clog2(RESP_CYC + 1) + 1;
    logic [WCW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (!rst_n || st != S_WRSP) wcnt <= '0;
        else                        wcnt <= wcnt + 1'b1;
    end

    p_enq_after_token_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && token_in && pending) |=> req_enq);

    p_pkt_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WRSP && rx_ack) |=> req_pkt);

    p_nak_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WRSP && rx_nak && !rx_ack) |=> (req_pass && !req_pkt));

    p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WRSP) |-> (wcnt < WCW'(RESP_CYC)));

    p_ok_needs_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[ST_OK]) |-> $past(rx_ack));

    p_busy_during_pkt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_pkt |-> !status[ST_AVAIL]);

    p_req_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_enq, req_pkt, req_pass}));

    p_pass_then_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_pass |=> (st == S_IDLE));

    p_idle_token_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && token_in && !pending) |=> (req_pass && !req_enq));

    p_busy_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |=> $stable(pending));

    p_irq_on_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(status[ST_OK]) && imask[ST_OK]) |-> irq);
endmodule

bind tkn_tx_seq tkn_tx_seq_chk #(.RESP_CYC(RESP_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .token_in(token_in),
    .rx_ack  (rx_ack),
    .rx_nak  (rx_nak),
    .req_enq (req_enq),
    .req_pkt (req_pkt),
    .req_pass(req_pass),
    .status  (status),
    .imask   (imask_q),
    .irq     (irq),
    .st      (st),
    .pending (pending)
);

// File: tb/tkn_tx_seq_tb.sv
module tkn_tx_seq_tb;
    localparam int ID_W     = 8;
    localparam int RESP_CYC = 16;
    localparam int ST_W     = 2;

    localparam logic [1:0] RP_NONE = 2'd0;
    localparam logic [1:0] RP_ACK  = 2'd1;
    localparam logic [1:0] RP_NAK  = 2'd2;

    typedef struct packed {
        logic [7:0] dest;
        logic [1:0] reply;
        logic [4:0] delay;
        logic       post_ack;
        logic       exp_pkt;
        logic [1:0] exp_status;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{8'h12, RP_ACK,  5'd0,  1'b1, 1'b1, 2'b11},
        '{8'h45, RP_ACK,  5'd3,  1'b0, 1'b1, 2'b01},
        '{8'hA0, RP_NAK,  5'd1,  1'b0, 1'b0, 2'b01},
        '{8'h07, RP_NONE, 5'd0,  1'b0, 1'b0, 2'b01},
        '{8'hFF, RP_ACK,  5'd15, 1'b1, 1'b1, 2'b11},
        '{8'h00, RP_NAK,  5'd15, 1'b0, 1'b0, 2'b01}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_enable = 1'b0;
    logic            cmd_disable = 1'b0;
    logic [ID_W-1:0] cmd_dest = '0;
    logic            imask_we = 1'b0;
    logic [ST_W-1:0] imask_wdata = '0;
    logic            token_in = 1'b0;
    logic            rx_ack = 1'b0;
    logic            rx_nak = 1'b0;
    logic            pkt_done = 1'b0;
    logic            req_enq;
    logic            req_pkt;
    logic            req_pass;
    logic [ID_W-1:0] req_dest;
    logic [ST_W-1:0] status;
    logic            irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tkn_tx_seq #(.ID_W(ID_W), .RESP_CYC(RESP_CYC)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_enable(cmd_enable), .cmd_disable(cmd_disable), .cmd_dest(cmd_dest),
        .imask_we(imask_we), .imask_wdata(imask_wdata),
        .token_in(token_in), .rx_ack(rx_ack), .rx_nak(rx_nak), .pkt_done(pkt_done),
        .req_enq(req_enq), .req_pkt(req_pkt), .req_pass(req_pass),
        .req_dest(req_dest), .status(status), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic give_token();
        token_in = 1'b1;
        tick();
        token_in = 1'b0;
    endtask

    task automatic pulse_ack();
        rx_ack = 1'b1;
        tick();
        rx_ack = 1'b0;
    endtask

    task automatic enable_tx(input logic [ID_W-1:0] d);
        cmd_enable = 1'b1;
        cmd_dest   = d;
        tick();
        cmd_enable = 1'b0;
    endtask

    // count cycles until req_pass shows up
    task automatic count_to_pass(output int n);
        n = 0;
        while (!req_pass && n < 3 * RESP_CYC) begin
            tick();
            n++;
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int n;
        string tag;
        tag = $sformatf("vec%0d", idx);
        enable_tx(v.dest);
        chk("R6", {tag, " avail clear after enable"}, int'(status[0]), 0);
        give_token();
        chk("R1", {tag, " req_enq"}, int'(req_enq), 1);
        chk("R1", {tag, " req_dest"}, int'(req_dest), int'(v.dest));
        tick();
        if (v.reply == RP_NONE) begin
            count_to_pass(n);
            chk("R4", {tag, " enquiry timeout cycles"}, n, RESP_CYC);
        end else begin
            repeat (int'(v.delay)) tick();
            chk("R4", {tag, " still waiting"}, int'({req_enq, req_pkt, req_pass}), 0);
            if (v.reply == RP_ACK) begin
                pulse_ack();
                chk("R2", {tag, " req_pkt after ack"}, int'(req_pkt), 1);
                tick();
                chk("R2", {tag, " req_pkt single cycle"}, int'(req_pkt), 0);
                pkt_done = 1'b1;
                tick();
                pkt_done = 1'b0;
                if (v.post_ack) begin
                    pulse_ack();
                    chk("R5", {tag, " pass after post ack"}, int'(req_pass), 1);
                end else begin
                    count_to_pass(n);
                    chk("R5", {tag, " post-packet silence cycles"}, n, RESP_CYC);
                end
            end else begin
                rx_nak = 1'b1;
                tick();
                rx_nak = 1'b0;
                chk("R3", {tag, " pass after nak"}, int'(req_pass), 1);
                chk("R3", {tag, " no packet after nak"}, int'(req_pkt), 0);
            end
        end
        chk("R5", {tag, " status at end"}, int'(status), int'(v.exp_status));
        chk("R6", {tag, " avail set at end"}, int'(status[0]), 1);
        tick();
        chk("R7", {tag, " requests idle after pass"}, int'({req_enq, req_pkt, req_pass}), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // reset state
        chk("R6", "reset status", int'(status), 1);
        chk("R10", "reset irq", int'(irq), 0);
        chk("R7", "reset requests", int'({req_enq, req_pkt, req_pass}), 0);

        // token with nothing pending
        give_token();
        chk("R8", "pass only without pending", int'({req_enq, req_pkt, req_pass}), 1);
        chk("R8", "status unchanged", int'(status), 1);
        tick();

        // table-driven attempts
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i);
        end

        // ack and nak together: ack wins
        enable_tx(8'h5A);
        give_token();
        tick();
        rx_ack = 1'b1;
        rx_nak = 1'b1;
        tick();
        rx_ack = 1'b0;
        rx_nak = 1'b0;
        chk("R2", "ack wins over nak", int'(req_pkt), 1);
        tick();
        pkt_done = 1'b1;
        tick();
        pkt_done = 1'b0;
        pulse_ack();
        chk("R5", "ack-wins attempt status", int'(status), 3);
        tick();

        // disable in idle cancels
        enable_tx(8'h21);
        chk("R6", "avail low while pending", int'(status[0]), 0);
        cmd_disable = 1'b1;
        tick();
        cmd_disable = 1'b0;
        chk("R9", "avail set by idle disable", int'(status[0]), 1);
        give_token();
        chk("R9", "cancelled: pass only", int'({req_enq, req_pkt, req_pass}), 1);
        tick();

        // commands during an attempt are ignored
        enable_tx(8'h3C);
        give_token();
        tick();
        cmd_disable = 1'b1;
        tick();
        cmd_disable = 1'b0;
        cmd_enable = 1'b1;
        cmd_dest   = 8'h99;
        tick();
        cmd_enable = 1'b0;
        pulse_ack();
        chk("R9", "packet despite mid disable", int'(req_pkt), 1);
        chk("R9", "dest unchanged by mid enable", int'(req_dest), 'h3C);
        tick();
        pkt_done = 1'b1;
        tick();
        pkt_done = 1'b0;
        pulse_ack();
        chk("R9", "attempt completes", int'(status), 3);
        tick();
        give_token();
        chk("R9", "mid enable not pending", int'({req_enq, req_pkt, req_pass}), 1);
        chk("R9", "status kept", int'(status), 3);
        tick();

        // interrupt masking
        imask_we = 1'b1; imask_wdata = 2'b10; tick(); imask_we = 1'b0;
        chk("R10", "irq from ok bit", int'(irq), 1);
        imask_we = 1'b1; imask_wdata = 2'b00; tick(); imask_we = 1'b0;
        chk("R10", "irq masked", int'(irq), 0);
        imask_we = 1'b1; imask_wdata = 2'b01; tick(); imask_we = 1'b0;
        chk("R10", "irq from avail bit", int'(irq), 1);
        enable_tx(8'h44);
        chk("R10", "irq drops with avail", int'(irq), 0);
        cmd_disable = 1'b1;
        tick();
        cmd_disable = 1'b0;
        chk("R10", "irq returns with avail", int'(irq), 1);

        // timeout wait count for a fresh attempt
        enable_tx(8'h66);
        give_token();
        tick();
        count_to_pass(n);
        chk("R4", "second timeout cycles", n, RESP_CYC);
        tick();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule